// File: doc/BRIEF.md
# Two-Sector Instruction Fetch Cache

This block sits between a processor's instruction fetch port and a single-ported program memory with a one-cycle read latency. It keeps two sectors of 32 instruction words. Each sector mirrors one 32-word-aligned block of program addresses, named by a tag made of the address bits above the 5-bit word offset. A fetch that finds its word in a sector is answered in the same cycle. Otherwise it misses. The whole sector that was not used most recently is then discarded, given the new tag and refilled from program memory. The refill reads the missed word first, hands it to the core as soon as it arrives, and then reads the rest of the block in ascending offset order, wrapping past the block end.

The core side uses a valid/ready handshake. The core raises `fetch_valid` with `fetch_addr` and must hold both steady until `fetch_ready` is high at a clock edge. `fetch_data` is meaningful only while `fetch_ready` is high. The cache exerts back-pressure by holding `fetch_ready` low: during a miss, during a direct memory read, and during a refill for any request whose word is not yet loaded. The memory side is a plain synchronous read port. `mem_rd_data` carries the word for the address presented with `mem_rd_en` one clock earlier. Two plain controls shape the behaviour. `lock` freezes the contents, so misses are answered by a single memory read and no sector is replaced. `bypass` sends every fetch to memory.

Top module: `sector_icache`

## Requirements
- R1: After reset no sector holds valid words: `fetch_ready` and `mem_rd_en` are low while no request is pending, and the first fetch after reset is a miss.
- R2: A fetch whose word is loaded in a sector that carries its tag gets `fetch_ready` high in the same cycle as `fetch_valid`, with the stored word on `fetch_data`.
- R3: On a miss the cache drives `mem_rd_en` with the missed address in the request cycle and keeps `fetch_ready` low. In the next cycle it raises `fetch_ready` with the memory word.
- R4: A refill performs exactly 32 memory reads on consecutive cycles. Read k (k = 0..31) targets the same tag (address bits above bit 4) at offset (missed offset + k) mod 32.
- R5: While a refill runs, a fetch to a word that has already been written into either sector is answered in the same cycle. A fetch to a word not yet written waits until that word is stored. A word read by refill step k is usable from the second cycle after the missed word was returned, plus k-1.
- R6: The victim of a refill is the sector other than the most recently used one. Both a hit and a completed refill mark a sector as most recently used.
- R7: A hit issues no memory read.
- R8: With `lock` high, a miss is served by one memory read with one cycle of latency, and no sector is replaced. Hits are still served from the sectors.
- R9: With `bypass` high, every fetch, including one to a cached word, is served by one memory read of its address, with `fetch_ready` one cycle after the request.
- R10: Raising `lock` or `bypass` during a refill does not shorten it. All 32 words are still loaded, and the new setting applies only to later requests.
- R11: `fetch_ready` is high only while `fetch_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | Core presents a fetch request |
| fetch_addr | input | ADDR_W | Word address of the fetch |
| fetch_ready | output | 1 | Request accepted this cycle, data valid |
| fetch_data | output | DATA_W | Instruction word returned to the core |
| lock | input | 1 | Freeze sector contents |
| bypass | input | 1 | Route every fetch to program memory |
| mem_rd_en | output | 1 | Program memory read strobe |
| mem_rd_addr | output | ADDR_W | Program memory read address |
| mem_rd_data | input | DATA_W | Program memory word, one cycle after the strobe |

## Verification
The bench watches the memory address sequence of a refill that starts in the middle of a block. A design that read the block from offset zero, or that did not wrap, would return the wrong word or log a wrong address order. It issues fetches while a refill is still running: one to the word just returned, one to a word written a cycle later, and one to a word far down the refill order. This exposes a design that stalls too long, or one that serves a word before it has been stored. Directed eviction sequences check the victim choice, because a design that evicted the recently hit sector would miss on it afterwards. Lock, bypass and a bypass raised in mid-refill are each checked by counting memory reads, which catches a refill cut short or a locked miss that replaced a sector. A seeded random mix then compares data and latency against a bench model of the tags and usage order.

// File: rtl/icache_pkg.sv
package icache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FILL   = 2'd1,
    ST_DIRECT = 2'd2
  } fsm_e;
endpackage

// File: rtl/icache_tags.sv
module icache_tags #(
  parameter int TAG_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TAG_W-1:0] look_tag,
  input  logic             retag_en,
  input  logic             retag_sel,
  input  logic [TAG_W-1:0] retag_val,
  output logic [1:0]       tag_match
);
  localparam int SECTORS = 2;

  for (genvar s = 0; s < SECTORS; s++) begin : g_sec
    logic [TAG_W-1:0] tag_q;
    logic             live_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tag_q  <= '0;
        live_q <= 1'b0;
      end else if (retag_en && (retag_sel == 1'(s))) begin
        tag_q  <= retag_val;
        live_q <= 1'b1;
      end
    end

    assign tag_match[s] = live_q && (tag_q == look_tag);
  end

  // R6
  sector_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tag_match));
endmodule

// File: rtl/icache_store.sv
module icache_store #(
  parameter int DATA_W = 16,
  parameter int OFF_W  = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [OFF_W-1:0]       rd_off,
  input  logic                   wr_en,
  input  logic                   wr_sel,
  input  logic [OFF_W-1:0]       wr_off,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic                   clr_en,
  input  logic                   clr_sel,
  output logic [1:0][DATA_W-1:0] rd_data,
  output logic [1:0]             rd_ok
);
  localparam int SECTORS = 2;
  localparam int WORDS   = 1 << OFF_W;

  for (genvar s = 0; s < SECTORS; s++) begin : g_sec
    logic [DATA_W-1:0] word_q [WORDS];
    logic [WORDS-1:0]  ok_q;

    always_ff @(posedge clk) begin
      if (wr_en && (wr_sel == 1'(s))) word_q[wr_off] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ok_q <= '0;
      end else if (clr_en && (clr_sel == 1'(s))) begin
        ok_q <= '0;
      end else if (wr_en && (wr_sel == 1'(s))) begin
        ok_q[wr_off] <= 1'b1;
      end
    end

    assign rd_data[s] = word_q[rd_off];
    assign rd_ok[s]   = ok_q[rd_off];
  end

  // R4
  clr_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(clr_en && wr_en && (clr_sel == wr_sel)));
endmodule

// File: rtl/icache_ctrl.sv
module icache_ctrl
  import icache_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16,
  parameter int OFF_W  = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   fetch_valid,
  input  logic [ADDR_W-1:0]      fetch_addr,
  output logic                   fetch_ready,
  output logic [DATA_W-1:0]      fetch_data,
  input  logic                   lock,
  input  logic                   bypass,
  output logic                   mem_rd_en,
  output logic [ADDR_W-1:0]      mem_rd_addr,
  input  logic [DATA_W-1:0]      mem_rd_data,
  input  logic [1:0]             tag_match,
  input  logic [1:0][DATA_W-1:0] rd_data,
  input  logic [1:0]             rd_ok,
  output logic                   retag_en,
  output logic                   retag_sel,
  output logic                   wr_en,
  output logic                   wr_sel,
  output logic [OFF_W-1:0]       wr_off,
  output logic                   clr_en,
  output logic                   clr_sel
);
  localparam int TAG_W = ADDR_W - OFF_W;
  localparam logic [OFF_W-1:0] LAST = '1;

  fsm_e             state_q, state_d;
  logic             lru_q, lru_d;
  logic             fill_sel_q, fill_sel_d;
  logic [TAG_W-1:0] fill_tag_q, fill_tag_d;
  logic [OFF_W-1:0] fill_off_q, fill_off_d;
  logic [OFF_W-1:0] cnt_q, cnt_d;

  logic [1:0] hit_vec;
  logic       hit, hit_sel;

  assign hit_vec = tag_match & rd_ok;
  assign hit     = |hit_vec;
  assign hit_sel = hit_vec[1];

  always_comb begin
    state_d     = state_q;
    lru_d       = lru_q;
    fill_sel_d  = fill_sel_q;
    fill_tag_d  = fill_tag_q;
    fill_off_d  = fill_off_q;
    cnt_d       = cnt_q;
    fetch_ready = 1'b0;
    fetch_data  = '0;
    mem_rd_en   = 1'b0;
    mem_rd_addr = fetch_addr;
    retag_en    = 1'b0;
    retag_sel   = ~lru_q;
    clr_en      = 1'b0;
    clr_sel     = ~lru_q;
    wr_en       = 1'b0;
    wr_sel      = fill_sel_q;
    wr_off      = fill_off_q + cnt_q;
    unique case (state_q)
      ST_IDLE: begin
        if (fetch_valid) begin
          if (bypass) begin
            mem_rd_en = 1'b1;
            state_d   = ST_DIRECT;
          end else if (hit) begin
            fetch_ready = 1'b1;
            fetch_data  = rd_data[hit_sel];
            lru_d       = hit_sel;
          end else if (lock) begin
            mem_rd_en = 1'b1;
            state_d   = ST_DIRECT;
          end else begin
            mem_rd_en  = 1'b1;
            retag_en   = 1'b1;
            clr_en     = 1'b1;
            fill_sel_d = ~lru_q;
            fill_tag_d = fetch_addr[ADDR_W-1:OFF_W];
            fill_off_d = fetch_addr[OFF_W-1:0];
            cnt_d      = '0;
            state_d    = ST_FILL;
          end
        end
      end
      ST_FILL: begin
        wr_en = 1'b1;
        if (cnt_q != LAST) begin
          mem_rd_en   = 1'b1;
          mem_rd_addr = {fill_tag_q, fill_off_q + cnt_q + OFF_W'(1)};
        end
        if (cnt_q == '0) begin
          fetch_ready = fetch_valid;
          fetch_data  = mem_rd_data;
        end else if (fetch_valid && !bypass && hit) begin
          fetch_ready = 1'b1;
          fetch_data  = rd_data[hit_sel];
          lru_d       = hit_sel;
        end
        cnt_d = cnt_q + OFF_W'(1);
        if (cnt_q == LAST) begin
          lru_d   = fill_sel_q;
          state_d = ST_IDLE;
        end
      end
      ST_DIRECT: begin
        fetch_ready = fetch_valid;
        fetch_data  = mem_rd_data;
        state_d     = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      lru_q      <= 1'b0;
      fill_sel_q <= 1'b0;
      fill_tag_q <= '0;
      fill_off_q <= '0;
      cnt_q      <= '0;
    end else begin
      state_q    <= state_d;
      lru_q      <= lru_d;
      fill_sel_q <= fill_sel_d;
      fill_tag_q <= fill_tag_d;
      fill_off_q <= fill_off_d;
      cnt_q      <= cnt_d;
    end
  end

  // R11
  ready_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_ready |-> fetch_valid);
  // R3
  miss_next_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && fetch_valid && !fetch_ready) |=> fetch_ready);
  // R9
  bypass_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && fetch_valid && bypass)
      |-> (mem_rd_en && mem_rd_addr == fetch_addr && !fetch_ready));
  // R7
  hit_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && fetch_ready) |-> !mem_rd_en);
  // R6
  lru_after_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FILL && cnt_q == LAST) |=> (lru_q == $past(fill_sel_q)));
  // R8
  lock_no_retag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && state_q == ST_IDLE) |-> !retag_en);
  // R4
  fill_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FILL && cnt_q != LAST) |-> mem_rd_en);
endmodule

// File: rtl/sector_icache.sv
module sector_icache #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16,
  parameter int OFF_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              fetch_ready,
  output logic [DATA_W-1:0] fetch_data,
  input  logic              lock,
  input  logic              bypass,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [DATA_W-1:0] mem_rd_data
);
  localparam int TAG_W = ADDR_W - OFF_W;

  logic [1:0]             tag_match;
  logic [1:0][DATA_W-1:0] rd_data;
  logic [1:0]             rd_ok;
  logic                   retag_en, retag_sel;
  logic                   wr_en, wr_sel;
  logic [OFF_W-1:0]       wr_off;
  logic                   clr_en, clr_sel;

  icache_tags #(.TAG_W(TAG_W)) u_tags (
    .clk       (clk),
    .rst_n     (rst_n),
    .look_tag  (fetch_addr[ADDR_W-1:OFF_W]),
    .retag_en  (retag_en),
    .retag_sel (retag_sel),
    .retag_val (fetch_addr[ADDR_W-1:OFF_W]),
    .tag_match (tag_match)
  );

  icache_store #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_off  (fetch_addr[OFF_W-1:0]),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_off  (wr_off),
    .wr_data (mem_rd_data),
    .clr_en  (clr_en),
    .clr_sel (clr_sel),
    .rd_data (rd_data),
    .rd_ok   (rd_ok)
  );

  icache_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .fetch_valid (fetch_valid),
    .fetch_addr  (fetch_addr),
    .fetch_ready (fetch_ready),
    .fetch_data  (fetch_data),
    .lock        (lock),
    .bypass      (bypass),
    .mem_rd_en   (mem_rd_en),
    .mem_rd_addr (mem_rd_addr),
    .mem_rd_data (mem_rd_data),
    .tag_match   (tag_match),
    .rd_data     (rd_data),
    .rd_ok       (rd_ok),
    .retag_en    (retag_en),
    .retag_sel   (retag_sel),
    .wr_en       (wr_en),
    .wr_sel      (wr_sel),
    .wr_off      (wr_off),
    .clr_en      (clr_en),
    .clr_sel     (clr_sel)
  );
endmodule

// File: tb/test_sector_icache.sv
`timescale 1ns/1ps
module test_sector_icache;
  localparam int AW = 12;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fv = 1'b0;
  logic [AW-1:0] fa = '0;
  logic          fetch_ready;
  logic [DW-1:0] fetch_data;
  logic          lock = 1'b0;
  logic          bypass = 1'b0;
  logic          mem_rd_en;
  logic [AW-1:0] mem_rd_addr;
  logic [DW-1:0] mem_rd_data = '0;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  int rd_n = 0;
  logic [AW-1:0] rd_log [64];

  always #2.5 clk = ~clk;

  sector_icache i_sector_icache (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fv), .fetch_addr(fa),
    .fetch_ready(fetch_ready), .fetch_data(fetch_data), .lock(lock),
    .bypass(bypass), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data)
  );

  function automatic logic [DW-1:0] pmem(input logic [AW-1:0] a);
    logic [31:0] t;
    t = 32'(a) * 32'h9E37 ^ 32'h5A5A;
    return t[DW-1:0];
  endfunction

  always @(posedge clk) begin
    if (mem_rd_en) begin
      mem_rd_data <= pmem(mem_rd_addr);
      if (rd_n < 64) rd_log[rd_n] = mem_rd_addr;
      rd_n = rd_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_fetch(input logic [AW-1:0] a, output logic [DW-1:0] d, output int lat);
    fv = 1'b1;
    fa = a;
    lat = 0;
    #1;
    while (!fetch_ready) begin
      @(negedge clk);
      #1;
      lat++;
    end
    d = fetch_data;
    @(negedge clk);
    fv = 1'b0;
  endtask

  task automatic fetch_chk(input logic [AW-1:0] a, input int exp_lat, input string req);
    logic [DW-1:0] d;
    int lat;
    do_fetch(a, d, lat);
    chk(d == pmem(a), req, int'(d), int'(pmem(a)));
    chk(lat == exp_lat, req, lat, exp_lat);
  endtask

  task automatic settle();
    repeat (34) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    if (!done) $display("  test done: total=%0d bad=%0d", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    bit [1:0][6:0] mt;
    bit [1:0]      mv;
    bit            mlru;
    int            bad_ord;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    // R1: idle outputs after reset
    chk(fetch_ready == 1'b0, "R1 ready idle", int'(fetch_ready), 0);
    chk(mem_rd_en == 1'b0, "R1 mem idle", int'(mem_rd_en), 0);
    @(negedge clk);
    rd_n = 0;
    // R1 and R3: first fetch misses, answered one cycle later
    fetch_chk(12'h0C5, 1, "R1/R3 first miss");
    settle();
    // R4: 32 reads, missed word first, wrapping order
    chk(rd_n == 32, "R4 refill reads", rd_n, 32);
    bad_ord = 0;
    for (int k = 0; k < 32; k++) begin
      if (rd_log[k] != {7'h06, 5'(5 + k)}) bad_ord++;
    end
    chk(bad_ord == 0, "R4 refill order", bad_ord, 0);
    // R2 and R7: hit same cycle, no memory traffic
    rd_n = 0;
    fetch_chk(12'h0D0, 0, "R2 hit");
    chk(rd_n == 0, "R7 hit no read", rd_n, 0);
    // R5: fetches during a refill
    fetch_chk(12'h13E, 1, "R5 miss start");
    fetch_chk(12'h13E, 0, "R5 loaded word");
    fetch_chk(12'h120, 1, "R5 next loaded word");
    fetch_chk(12'h134, 19, "R5 late word");
    settle();
    // R6: hit tag 6, then miss evicts tag 9
    fetch_chk(12'h0C0, 0, "R6 hit old");
    fetch_chk(12'h140, 1, "R6 miss new");
    settle();
    fetch_chk(12'h0C3, 0, "R6 kept sector");
    fetch_chk(12'h125, 1, "R6 evicted sector");
    settle();
    // R8: lock
    lock = 1'b1;
    rd_n = 0;
    fetch_chk(12'h1F0, 1, "R8 locked miss");
    chk(rd_n == 1, "R8 single read", rd_n, 1);
    fetch_chk(12'h1F0, 1, "R8 still uncached");
    fetch_chk(12'h0C7, 0, "R8 hit under lock");
    lock = 1'b0;
    fetch_chk(12'h127, 0, "R8 sector not replaced");
    // R9: bypass
    bypass = 1'b1;
    rd_n = 0;
    fetch_chk(12'h0C7, 1, "R9 bypass cached word");
    chk(rd_n == 1, "R9 one read", rd_n, 1);
    chk(rd_log[0] == 12'h0C7, "R9 read addr", int'(rd_log[0]), 'h0C7);
    bypass = 1'b0;
    // R10: bypass and lock raised mid refill
    rd_n = 0;
    fetch_chk(12'h200, 1, "R10 miss");
    bypass = 1'b1;
    lock = 1'b1;
    settle();
    chk(rd_n == 32, "R10 refill complete", rd_n, 32);
    bypass = 1'b0;
    lock = 1'b0;
    fetch_chk(12'h21F, 0, "R10 last word loaded");

    // random phase against a model, from a fresh reset
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    mv = '0;
    mt = '0;
    mlru = 1'b0;
    void'($urandom(32'd4711));
    for (int i = 0; i < 400; i++) begin
      logic [AW-1:0] a;
      int hs;
      int el;
      bit lk, bp;
      a = {5'($urandom_range(8, 11)), 2'b00, 5'($urandom_range(0, 31))};
      lk = ($urandom_range(0, 5) == 0);
      bp = ($urandom_range(0, 5) == 0);
      lock = lk;
      bypass = bp;
      hs = -1;
      if (mv[0] && mt[0] == a[AW-1:5]) hs = 0;
      if (mv[1] && mt[1] == a[AW-1:5]) hs = 1;
      el = (!bp && hs >= 0) ? 0 : 1;
      fetch_chk(a, el, "R2/R3/R6/R8/R9 random");
      if (!bp && hs >= 0) begin
        mlru = hs[0];
      end else if (!bp && !lk) begin
        mt[~mlru] = a[AW-1:5];
        mv[~mlru] = 1'b1;
        mlru = ~mlru;
        lock = 1'b0;
        bypass = 1'b0;
        settle();
      end
      // R11: ready low with no request
      #1;
      chk(fetch_ready == 1'b0, "R11 no ready without valid", int'(fetch_ready), 0);
      @(negedge clk);
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule